// File: doc/BRIEF.md
# Page Access Permission and Protection-Key Checker

This block sits at the end of an address-translation walk. The walker hands it three combined attribute bits for the final mapping: user-accessible, writable and no-execute. It also hands over the final 64-bit entry and a status code saying whether the walk completed. The checker works out which of read, write and execute the current privilege mode may use on that page. It narrows that set by the per-key access rights of the page's protection key. It then decides whether the requested access is allowed and, when it is not, builds the page-fault error code that the fault logic reports.

Two 32-bit rights registers hold two bits per key, one register for user pages and one for supervisor pages. The page's user bit picks the register, and only when long mode and the matching key enable are both on. The mode rules cover write protection for supervisor writes, the ban on supervisor fetches from user pages, and a restricted supervisor mode that may not read user pages. Results are registered: each sampled request produces its verdict one clock later, and the verdict holds until the next request.

Top module: `pgperm_chk`

## Requirements
- R1: A user-mode access (`mode` 2 or 3) to a page whose `eff_user` is 0 is a protection fault: `fault`=1, error bit 0 (P)=1, error bit 5 (PK)=0, whatever the key rights say.
- R2: Read is in the permission set unless `mode`=1 (restricted supervisor) and `eff_user`=1.
- R3: Write is in the permission set only when read is, and either `eff_write`=1 or the access is supervisor-mode (`mode` 0 or 1) with `wp_en`=0.
- R4: Execute is in the permission set when `eff_nx`=0 and either the access is user-mode or not (`xprot_en`=1 and `eff_user`=1). Key rights never remove execute.
- R5: Key rights apply only when `long_mode`=1. A page with `eff_user`=1 uses `ukey_rights` if `ukey_en`=1, and a page with `eff_user`=0 uses `skey_rights` if `skey_en`=1. In every other case the rights are all zero and have no effect.
- R6: For key k, rights bit 2k (access-disable) removes read and write. Rights bit 2k+1 (write-disable) removes write, but only when the access is user-mode or `wp_en`=1.
- R7: When the key rights alone deny the requested access, and R1 has not already faulted, the fault sets error bit 5 (PK) and bit 0 (P).
- R8: Error code bits: 0 P, 1 W (access is a write), 2 U (user-mode), 3 RSVD, 4 I/D, 5 PK; all other bits are 0. The error code is all zero when there is no fault. `walk_stat` 0 means the walk completed. `walk_stat` 1 means not present: it faults with P=0. `walk_stat` 2 or 3 means a reserved-bit fault: it faults with P=1 and RSVD=1. Either walk fault reports an empty permission set.
- R9: Error bit 4 (I/D) is set on a faulting fetch when (`nx_en`=1 and `ext_fmt`=1) or `xprot_en`=1.
- R10: `acc_type` 0 is read, 1 is write, 2 is fetch, and 3 is treated as read. A completed walk faults exactly when the permission bit that the access type needs is missing from the final set.
- R11: The protection key is bits 62:59 of `entry`; no other entry bit affects the result.
- R12: Outputs update one clock after a cycle with `in_valid`=1, with `out_valid`=1 in that cycle only. Without `in_valid` all result outputs hold. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| entry | input | 64 | Final table entry (key in bits 62:59) |
| eff_user | input | 1 | Combined user-accessible bit |
| eff_write | input | 1 | Combined writable bit |
| eff_nx | input | 1 | Combined no-execute bit |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| mode | input | 2 | 0 supervisor, 1 restricted supervisor, 2/3 user |
| walk_stat | input | 2 | 0 done, 1 not present, 2/3 reserved-bit |
| wp_en | input | 1 | Write protection for supervisor writes |
| xprot_en | input | 1 | Supervisor fetch from user pages forbidden |
| nx_en | input | 1 | No-execute feature enabled |
| ext_fmt | input | 1 | Extended (64-bit entry) table format active |
| long_mode | input | 1 | Long mode active |
| ukey_en | input | 1 | Keys enabled for user pages |
| skey_en | input | 1 | Keys enabled for supervisor pages |
| ukey_rights | input | 32 | Rights register for user pages |
| skey_rights | input | 32 | Rights register for supervisor pages |
| out_valid | output | 1 | Result valid pulse |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| fault | output | 1 | Requested access denied |
| err_code | output | 16 | Page-fault error code |

## Verification
Every result comes from a single register stage. A request sampled at one rising edge therefore shows its permissions, fault flag and error code at the ports right after that edge, together with `out_valid`. The bench changes inputs on falling edges and compares each vector at the next falling edge, half a cycle after the results were captured, so no check depends on the order of processes at a clock edge. The hold rule is checked by lowering `in_valid`, scrambling every input, and confirming one cycle later that the previous verdict is still at the ports with `out_valid` low.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSV   = 2'd3
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  // error code bit positions (consumed by the fault logic)
  localparam int EB_P    = 0;
  localparam int EB_W    = 1;
  localparam int EB_U    = 2;
  localparam int EB_RSVD = 3;
  localparam int EB_ID   = 4;
  localparam int EB_PK   = 5;

  // user-mode when the upper mode bit is set
  function automatic logic is_user_mode(input logic [1:0] md);
    return md[1];
  endfunction

  // restricted supervisor: may not read user pages
  function automatic logic is_restricted(input logic [1:0] md);
    return (md == 2'd1);
  endfunction

  // does a permission set cover the requested access type
  function automatic logic covers(input perm_t p, input logic [1:0] acc);
    logic ok;
    case (acc)
      2'd1:    ok = p.w;
      2'd2:    ok = p.x;
      default: ok = p.r;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pgperm_base.sv
// Mode-dependent permission derivation from the combined walk bits.
module pgperm_base
  import pgperm_pkg::*;
(
  input  logic       eff_user,
  input  logic       eff_write,
  input  logic       eff_nx,
  input  logic [1:0] mode,
  input  logic       wp_en,
  input  logic       xprot_en,
  output perm_t      base_perm
);

  logic umode;
  logic restr;
  logic rd_ok;
  logic wr_ok;
  logic ex_ok;

  assign umode = is_user_mode(mode);
  assign restr = is_restricted(mode);

  always_comb begin
    rd_ok = !(restr && eff_user);
    wr_ok = rd_ok && (eff_write || (!umode && !wp_en));
    ex_ok = !eff_nx && (umode || !(xprot_en && eff_user));
  end

  assign base_perm = '{r: rd_ok, w: wr_ok, x: ex_ok};

endmodule

// File: rtl/pgperm_key.sv
// Protection-key rights selection and masking.
module pgperm_key
  import pgperm_pkg::*;
#(
  parameter  int KEY_W    = 4,
  localparam int NKEYS    = 1 << KEY_W,
  localparam int RIGHTS_W = 2 * NKEYS
) (
  input  logic [KEY_W-1:0]    key,
  input  logic                page_user,
  input  logic                umode,
  input  logic                wp_en,
  input  logic                long_mode,
  input  logic                ukey_en,
  input  logic                skey_en,
  input  logic [RIGHTS_W-1:0] ukey_rights,
  input  logic [RIGHTS_W-1:0] skey_rights,
  output perm_t               key_mask
);

  logic [RIGHTS_W-1:0] rights_sel;
  logic [NKEYS-1:0]    ad_vec;
  logic [NKEYS-1:0]    wd_vec;
  logic                ad_bit;
  logic                wd_bit;

  always_comb begin
    rights_sel = '0;
    if (long_mode) begin
      if (page_user) rights_sel = ukey_en ? ukey_rights : '0;
      else           rights_sel = skey_en ? skey_rights : '0;
    end
  end

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    assign ad_vec[k] = rights_sel[2*k];
    assign wd_vec[k] = rights_sel[2*k+1];
  end

  assign ad_bit = ad_vec[key];
  assign wd_bit = wd_vec[key];

  assign key_mask = '{r: !ad_bit,
                      w: !ad_bit && !(wd_bit && (umode || wp_en)),
                      x: 1'b1};

endmodule

// File: rtl/pgperm_err.sv
// Fault decision and error-code assembly.
module pgperm_err
  import pgperm_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic [1:0]       walk_stat,
  input  logic [1:0]       acc_type,
  input  logic             umode,
  input  logic             nx_en,
  input  logic             ext_fmt,
  input  logic             xprot_en,
  input  logic             user_flt,
  input  logic             key_flt,
  input  logic             perm_flt,
  output logic             fault,
  output logic [ERR_W-1:0] err_code
);

  logic walk_ok;
  logic walk_np;
  logic walk_rs;
  logic prot_any;

  assign walk_ok  = (walk_stat == 2'd0);
  assign walk_np  = (walk_stat == 2'd1);
  assign walk_rs  = !walk_ok && !walk_np;
  assign prot_any = walk_ok && (user_flt || key_flt || perm_flt);

  always_comb begin
    fault    = !walk_ok || prot_any;
    err_code = '0;
    if (fault) begin
      err_code[EB_P]    = walk_rs || prot_any;
      err_code[EB_W]    = (acc_type == ACC_WRITE);
      err_code[EB_U]    = umode;
      err_code[EB_RSVD] = walk_rs;
      err_code[EB_ID]   = (acc_type == ACC_FETCH) && ((nx_en && ext_fmt) || xprot_en);
      err_code[EB_PK]   = walk_ok && !user_flt && key_flt;
    end
  end

endmodule

// File: rtl/pgperm_chk.sv
// Page access permission and protection-key checker (top).
module pgperm_chk
  import pgperm_pkg::*;
#(
  parameter  int ENTRY_W  = 64,
  parameter  int KEY_W    = 4,
  parameter  int KEY_LSB  = 59,
  parameter  int ERR_W    = 16,
  localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ENTRY_W-1:0]  entry,
  input  logic                eff_user,
  input  logic                eff_write,
  input  logic                eff_nx,
  input  logic [1:0]          acc_type,
  input  logic [1:0]          mode,
  input  logic [1:0]          walk_stat,
  input  logic                wp_en,
  input  logic                xprot_en,
  input  logic                nx_en,
  input  logic                ext_fmt,
  input  logic                long_mode,
  input  logic                ukey_en,
  input  logic                skey_en,
  input  logic [RIGHTS_W-1:0] ukey_rights,
  input  logic [RIGHTS_W-1:0] skey_rights,
  output logic                out_valid,
  output logic                perm_r,
  output logic                perm_w,
  output logic                perm_x,
  output logic                fault,
  output logic [ERR_W-1:0]    err_code
);

  // named internal events
  logic             umode;
  logic [KEY_W-1:0] page_key;
  perm_t            base_perm;
  perm_t            key_mask;
  perm_t            final_perm;
  perm_t            rep_perm;
  logic             user_flt;
  logic             key_flt;
  logic             perm_flt;
  logic             fault_d;
  logic [ERR_W-1:0] err_d;

  assign umode    = is_user_mode(mode);
  assign page_key = entry[KEY_LSB +: KEY_W];

  pgperm_base u_base (
    .eff_user  (eff_user),
    .eff_write (eff_write),
    .eff_nx    (eff_nx),
    .mode      (mode),
    .wp_en     (wp_en),
    .xprot_en  (xprot_en),
    .base_perm (base_perm)
  );

  pgperm_key #(.KEY_W(KEY_W)) u_key (
    .key         (page_key),
    .page_user   (eff_user),
    .umode       (umode),
    .wp_en       (wp_en),
    .long_mode   (long_mode),
    .ukey_en     (ukey_en),
    .skey_en     (skey_en),
    .ukey_rights (ukey_rights),
    .skey_rights (skey_rights),
    .key_mask    (key_mask)
  );

  assign final_perm = base_perm & key_mask;
  assign user_flt   = umode && !eff_user;
  assign key_flt    = !covers(key_mask, acc_type);
  assign perm_flt   = !covers(final_perm, acc_type);
  assign rep_perm   = (walk_stat == 2'd0) ? final_perm : '0;

  pgperm_err #(.ERR_W(ERR_W)) u_err (
    .walk_stat (walk_stat),
    .acc_type  (acc_type),
    .umode     (umode),
    .nx_en     (nx_en),
    .ext_fmt   (ext_fmt),
    .xprot_en  (xprot_en),
    .user_flt  (user_flt),
    .key_flt   (key_flt),
    .perm_flt  (perm_flt),
    .fault     (fault_d),
    .err_code  (err_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      perm_r    <= 1'b0;
      perm_w    <= 1'b0;
      perm_x    <= 1'b0;
      fault     <= 1'b0;
      err_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        perm_r   <= rep_perm.r;
        perm_w   <= rep_perm.w;
        perm_x   <= rep_perm.x;
        fault    <= fault_d;
        err_code <= err_d;
      end
    end
  end

  // R12
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(fault) && $stable(err_code) && $stable(perm_w)));
  // R1
  user_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && umode && !eff_user && walk_stat == 2'd0)
      |=> (fault && err_code[EB_P] && !err_code[EB_PK]));
  // R7
  pk_implies_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_code[EB_PK] |-> (fault && err_code[EB_P]));
  // R8
  clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (err_code == '0));
  // R3
  write_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_w |-> perm_r);
  // R8
  write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (err_code[EB_W] == (fault && $past(acc_type) == 2'd1)));

endmodule

// File: tb/sim_pgperm_chk.sv
module sim_pgperm_chk;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] entry = '0;
  logic        eff_user = 0, eff_write = 0, eff_nx = 0;
  logic [1:0]  acc_type = 0, mode = 0, walk_stat = 0;
  logic        wp_en = 0, xprot_en = 0, nx_en = 0, ext_fmt = 0;
  logic        long_mode = 0, ukey_en = 0, skey_en = 0;
  logic [31:0] ukey_rights = '0, skey_rights = '0;
  logic        out_valid, perm_r, perm_w, perm_x, fault;
  logic [15:0] err_code;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pgperm_chk u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .entry(entry),
    .eff_user(eff_user), .eff_write(eff_write), .eff_nx(eff_nx),
    .acc_type(acc_type), .mode(mode), .walk_stat(walk_stat),
    .wp_en(wp_en), .xprot_en(xprot_en), .nx_en(nx_en), .ext_fmt(ext_fmt),
    .long_mode(long_mode), .ukey_en(ukey_en), .skey_en(skey_en),
    .ukey_rights(ukey_rights), .skey_rights(skey_rights),
    .out_valid(out_valid), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .fault(fault), .err_code(err_code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected result {r,w,x,fault,err[5:0]} restated from the requirements
  function automatic logic [9:0] model();
    logic um, r, w, x, kr, kw, ad, wd, need, needk, flt, p, rs, pk, id;
    logic [31:0] rights;
    logic [3:0]  k;
    um = (mode >= 2'd2);
    r  = !(mode == 2'd1 && eff_user);
    w  = r && (eff_write || (!um && !wp_en));
    x  = !eff_nx && (um || !(xprot_en && eff_user));
    rights = 32'h0;
    if (long_mode && eff_user && ukey_en)  rights = ukey_rights;
    if (long_mode && !eff_user && skey_en) rights = skey_rights;
    k  = entry[62:59];
    ad = rights[{k, 1'b0}];
    wd = rights[{k, 1'b1}];
    kr = !ad;
    kw = !ad && !(wd && (um || wp_en));
    r = r & kr;
    w = w & kw;
    need  = (acc_type == 2'd1) ? w  : (acc_type == 2'd2) ? x    : r;
    needk = (acc_type == 2'd1) ? kw : (acc_type == 2'd2) ? 1'b1 : kr;
    flt = 0; p = 0; rs = 0; pk = 0;
    if (walk_stat != 2'd0) begin
      flt = 1; p = (walk_stat != 2'd1); rs = p; r = 0; w = 0; x = 0;
    end else if (um && !eff_user) begin
      flt = 1; p = 1;
    end else if (!needk) begin
      flt = 1; p = 1; pk = 1;
    end else if (!need) begin
      flt = 1; p = 1;
    end
    id = flt && acc_type == 2'd2 && ((nx_en && ext_fmt) || xprot_en);
    if (!flt) return {r, w, x, 7'b0};
    return {r, w, x, 1'b1, pk, id, rs, um, (acc_type == 2'd1), p};
  endfunction

  task automatic sweep_check(input logic [9:0] e, input logic keys_on);
    check(keys_on ? "R6 read" : "R2 read", perm_r, e[9]);
    check(keys_on ? "R6 write" : "R3 write", perm_w, e[8]);
    check("R4 exec", perm_x, e[7]);
    check("R10 fault", fault, e[6]);
    check("R8 code", {err_code[15:6], err_code[3:0]}, {10'b0, e[3:0]});
    check("R9 id", err_code[4], e[4]);
    check("R7 pk", err_code[5], e[5]);
    check("R12 valid", out_valid, 1'b1);
  endtask

  initial begin : watchdog
    #(20 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [9:0] e;
    int idx;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {out_valid, perm_r, perm_w, perm_x, fault, err_code}, 21'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // near-exhaustive sweep
    ukey_rights = 32'hA5C3_6E19;
    skey_rights = 32'h5A3C_91E6;
    idx = 0;
    in_valid = 1'b1;
    for (int ws = 0; ws < 4; ws++)
    for (int lm = 0; lm < 2; lm++)
    for (int ke = 0; ke < 4; ke++)
    for (int cf = 0; cf < 16; cf++)
    for (int md = 0; md < 4; md++)
    for (int ac = 0; ac < 4; ac++)
    for (int eb = 0; eb < 8; eb++) begin
      walk_stat = ws[1:0];
      long_mode = lm[0];
      ukey_en = ke[0]; skey_en = ke[1];
      {wp_en, xprot_en, nx_en, ext_fmt} = cf[3:0];
      mode = md[1:0];
      acc_type = ac[1:0];
      {eff_user, eff_write, eff_nx} = eb[2:0];
      entry = 64'hC3A5_0F96_E1D2_7B48 ^ (64'(idx) * 64'h9E37_79B9_7F4A_7C15);
      entry[62:59] = 4'(idx * 5 + (idx >> 4));
      e = model();
      @(negedge clk);
      sweep_check(e, lm[0] && (eff_user ? ke[0] : ke[1]));
      idx++;
    end

    // R5: long mode off -> rights ignored
    walk_stat = 0; long_mode = 0; ukey_en = 1; skey_en = 1;
    ukey_rights = '1; skey_rights = '1;
    mode = 2; eff_user = 1; eff_write = 1; eff_nx = 0; acc_type = 1; wp_en = 1;
    @(negedge clk);
    check("R5 no long mode", {fault, perm_w}, 2'b01);
    // R5: user page with user keys disabled ignores supervisor register
    long_mode = 1; ukey_en = 0; skey_en = 1; ukey_rights = '0;
    @(negedge clk);
    check("R5 user page sup reg", {fault, perm_w}, 2'b01);
    // R5: supervisor page uses supervisor register
    mode = 0; eff_user = 0; acc_type = 0;
    @(negedge clk);
    check("R5 sup page", {fault, err_code[5], perm_r}, 3'b110);

    // R6: write-disable with supervisor and wp off leaves write
    skey_rights = 32'hAAAA_AAAA; wp_en = 0; acc_type = 1;
    @(negedge clk);
    check("R6 wd sup wp off", {fault, perm_w, perm_r}, 3'b011);
    wp_en = 1;
    @(negedge clk);
    check("R6 wd sup wp on", {fault, err_code[5:0]}, 7'b1_100011);
    // R6: access-disable never blocks fetch
    skey_rights = '1; acc_type = 2; xprot_en = 0;
    @(negedge clk);
    check("R6 fetch unaffected", {fault, perm_x}, 2'b01);

    // R11: only bits 62:59 select the key
    skey_rights = 32'h0000_0040;     // key 3 access-disabled only
    acc_type = 0;
    entry = 64'h0;
    entry[62:59] = 4'd3;
    @(negedge clk);
    check("R11 key 3 denied", {fault, err_code[5]}, 2'b11);
    entry = 64'h87FF_FFFF_FFFF_FFFF; // bits 62:59 = 0, all else set
    @(negedge clk);
    check("R11 other bits ignored", {fault, perm_r}, 2'b01);

    // R1: user-mode on supervisor page with keys that would also deny
    mode = 2; eff_user = 0; entry[62:59] = 4'd3; acc_type = 0;
    @(negedge clk);
    check("R1 user on sup page", {fault, err_code[5:0]}, 7'b1_000101);

    // R12: hold without in_valid
    in_valid = 0;
    mode = 0; eff_user = 1; eff_write = 1; long_mode = 0; acc_type = 1; walk_stat = 1;
    @(negedge clk);
    check("R12 hold", {out_valid, fault, err_code[5:0]}, 8'b0_1_000101);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule